// File: doc/BRIEF.md
# Stream Core Run-State Controller

This block sequences a programmable stream-processing core through its run states. Three level control inputs (enable, pause, halt) are sampled every cycle and move a registered state machine between idle, run, wait and pause. Halt is the strongest of the three. A halt-mode input chooses what happens to a write-back that is still in flight. In one mode the controller waits for it to finish. In the other it drops the write-back and reports that with a pulse.

The controller also follows end-of-frame events. It latches the byte count carried with the first unhandled end-of-frame, and it flags an overload when another end-of-frame arrives before the earlier one was acknowledged. A write-one clear wipes both. Each end-of-frame loads a tail-bit counter that counts down the extra bits the core still has to process, and a done pulse marks the end of that count. A read-hold output tells the core whether it must still wait for read data after end-of-frame. A write-one strobe produces a one-cycle FIFO reset. A five-bit status word reports the state one-hot in bits 3..0 and the registered FIFO-empty indication in bit 4.

Top module: `strm_runctl`

## Requirements
- R1: After synchronous reset, status reads 5'b10001 (bit 0 idle, bit 4 FIFO empty), eof_cnt is 0, eof_ovf is 0, fifo_rst_pulse and tail_done are 0. Exactly one of status bits 3..0 (bit0 idle, bit1 run, bit2 wait, bit3 pause) is set at all times.
- R2: With ctl_en=1, ctl_halt=0 and ctl_pause=0 sampled at an edge, status shows run (bit 1) after that edge.
- R3: Pause has priority over run and halt has priority over pause. With halt 0, enable 1 and pause 1, the state becomes pause (bit 3). With halt 1, the state is never run.
- R4: With halt_drop=0, asserting halt while not idle and wb_busy=1 enters wait (bit 2). The state stays in wait while wb_busy stays 1 and goes idle on the first edge that samples wb_busy=0.
- R5: With halt_drop=1, asserting halt goes idle on the next edge. If wb_busy was 1 and the state was not idle, wb_drop pulses for that one cycle.
- R6: With halt=0 and ctl_en=0, the state becomes idle.
- R7: An end-of-frame (eof_in=1) accepted while none is pending (or in the same cycle as eof_ack) and with no overload latches byte_cnt into eof_cnt on the next edge.
- R8: An end-of-frame arriving while an earlier one is pending and not acknowledged in that cycle sets eof_ovf. While eof_ovf is 1, eof_cnt keeps its value.
- R9: trace_clr_wr=1 clears eof_cnt, eof_ovf and the pending end-of-frame on the next edge, taking priority over a simultaneous end-of-frame.
- R10: Each end-of-frame loads tail_left with tail_len. tail_left decrements once per bit_step cycle only while the state is run. tail_done pulses for one cycle in the cycle tail_left reaches 0, or directly after an end-of-frame with tail_len 0.
- R11: An end-of-frame with rd_skip=0 sets rd_hold until rd_valid is seen. With rd_skip=1, rd_hold is not set.
- R12: A rising fifo_rst_wr gives fifo_rst_pulse=1 for exactly one cycle, even if the strobe is held. Status bit 4 follows fifo_empty_in with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Core enable level |
| ctl_pause | input | 1 | Pause request level |
| ctl_halt | input | 1 | Halt request level |
| halt_drop | input | 1 | Halt mode: 0 drains write-back, 1 drops it |
| wb_busy | input | 1 | Write-back in progress |
| rd_skip | input | 1 | 1: do not wait for read data after end-of-frame |
| rd_valid | input | 1 | Read data arrived |
| eof_in | input | 1 | End-of-frame event strobe |
| eof_ack | input | 1 | Earlier end-of-frame handled |
| byte_cnt | input | 14 | Byte count presented with end-of-frame |
| tail_len | input | 16 | Extra bits to process after end-of-frame |
| bit_step | input | 1 | One bit processed this cycle |
| trace_clr_wr | input | 1 | Write-one clear of end-of-frame trace |
| fifo_rst_wr | input | 1 | Write-one FIFO reset strobe |
| fifo_empty_in | input | 1 | FIFO empty indication |
| status | output | 5 | {fifo empty, pause, wait, run, idle} |
| wb_drop | output | 1 | Write-back abandoned by halt |
| eof_cnt | output | 14 | Captured end-of-frame byte count |
| eof_ovf | output | 1 | End-of-frame lost |
| tail_left | output | 16 | Remaining tail bits |
| tail_done | output | 1 | Tail count finished pulse |
| rd_hold | output | 1 | Waiting for read data after end-of-frame |
| fifo_rst_pulse | output | 1 | One-cycle FIFO reset |

## Verification
The state machine is driven through a sequence of control levels that includes each priority pair (pause against run, halt against pause), halt in both modes with write-back busy and idle, and enable removal. These cases separate a wrong priority order from a wrong drain rule. End-of-frame trace is tried with an isolated event, with a second event before acknowledge, with an event in the same cycle as acknowledge, and with a clear. These show whether capture, overload hold and clear are kept apart. The tail counter is run with a nonzero length while running, with a zero length, and while paused, which shows both the countdown and its run gating.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PAUSE = 2'd3
  } run_st_t;
endpackage

// File: rtl/scr_run_fsm.sv
module scr_run_fsm
  import scr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  logic    pause,
  input  logic    halt,
  input  logic    halt_drop,
  input  logic    wb_busy,
  output run_st_t state,
  output logic    wb_drop
);
  run_st_t nxt;
  logic    drop_nxt;

  always_comb begin
    nxt      = state;
    drop_nxt = 1'b0;
    if (halt) begin
      // halt outranks everything; mode picks drain or abandon
      if (state != ST_IDLE && wb_busy && !halt_drop) begin
        nxt = ST_WAIT;
      end else begin
        nxt      = ST_IDLE;
        drop_nxt = (state != ST_IDLE) && wb_busy && halt_drop;
      end
    end else if (!en) begin
      nxt = ST_IDLE;
    end else if (pause) begin
      nxt = ST_PAUSE;
    end else begin
      nxt = ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      wb_drop <= 1'b0;
    end else begin
      state   <= nxt;
      wb_drop <= drop_nxt;
    end
  end
endmodule

// File: rtl/scr_eof_trace.sv
module scr_eof_trace #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eof_in,
  input  logic             eof_ack,
  input  logic             clr,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             rd_skip,
  input  logic             rd_valid,
  output logic [CNT_W-1:0] eof_cnt,
  output logic             eof_ovf,
  output logic             rd_hold
);
  logic pending;
  logic accept;

  assign accept = eof_in && (!pending || eof_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      eof_cnt <= '0;
      eof_ovf <= 1'b0;
    end else if (clr) begin
      pending <= 1'b0;
      eof_cnt <= '0;
      eof_ovf <= 1'b0;
    end else begin
      if (accept) begin
        pending <= 1'b1;
        if (!eof_ovf) eof_cnt <= byte_cnt;
      end else if (eof_in) begin
        eof_ovf <= 1'b1;
      end else if (eof_ack) begin
        pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold <= 1'b0;
    end else if (eof_in && !rd_skip) begin
      rd_hold <= 1'b1;
    end else if (rd_valid) begin
      rd_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/scr_tail_ctr.sv
module scr_tail_ctr #(
  parameter int TAIL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TAIL_W-1:0] len,
  input  logic              step,
  output logic [TAIL_W-1:0] left,
  output logic              done
);
  localparam logic [TAIL_W-1:0] ONE = TAIL_W'(1);
  logic active;

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      left   <= len;
      active <= (len != '0);
      done   <= (len == '0);
    end else if (active && step) begin
      left   <= left - ONE;
      active <= (left != ONE);
      done   <= (left == ONE);
    end else begin
      done   <= 1'b0;
    end
  end
endmodule

// File: rtl/strm_runctl.sv
module strm_runctl
  import scr_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int TAIL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_en,
  input  logic              ctl_pause,
  input  logic              ctl_halt,
  input  logic              halt_drop,
  input  logic              wb_busy,
  input  logic              rd_skip,
  input  logic              rd_valid,
  input  logic              eof_in,
  input  logic              eof_ack,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [TAIL_W-1:0] tail_len,
  input  logic              bit_step,
  input  logic              trace_clr_wr,
  input  logic              fifo_rst_wr,
  input  logic              fifo_empty_in,
  output logic [4:0]        status,
  output logic              wb_drop,
  output logic [CNT_W-1:0]  eof_cnt,
  output logic              eof_ovf,
  output logic [TAIL_W-1:0] tail_left,
  output logic              tail_done,
  output logic              rd_hold,
  output logic              fifo_rst_pulse
);
  run_st_t st;
  logic    empty_q;
  logic    fifo_wr_d;

  scr_run_fsm u_fsm (
    .clk(clk), .rst(rst), .en(ctl_en), .pause(ctl_pause), .halt(ctl_halt),
    .halt_drop(halt_drop), .wb_busy(wb_busy), .state(st), .wb_drop(wb_drop)
  );

  scr_eof_trace #(.CNT_W(CNT_W)) u_eof (
    .clk(clk), .rst(rst), .eof_in(eof_in), .eof_ack(eof_ack),
    .clr(trace_clr_wr), .byte_cnt(byte_cnt), .rd_skip(rd_skip),
    .rd_valid(rd_valid), .eof_cnt(eof_cnt), .eof_ovf(eof_ovf),
    .rd_hold(rd_hold)
  );

  scr_tail_ctr #(.TAIL_W(TAIL_W)) u_tail (
    .clk(clk), .rst(rst), .load(eof_in), .len(tail_len),
    .step(bit_step && (st == ST_RUN)), .left(tail_left), .done(tail_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q        <= 1'b1;
      fifo_wr_d      <= 1'b0;
      fifo_rst_pulse <= 1'b0;
    end else begin
      empty_q        <= fifo_empty_in;
      fifo_wr_d      <= fifo_rst_wr;
      fifo_rst_pulse <= fifo_rst_wr && !fifo_wr_d;
    end
  end

  assign status = {empty_q, st == ST_PAUSE, st == ST_WAIT, st == ST_RUN, st == ST_IDLE};
endmodule

// File: rtl/strm_runctl_chk.sv
module strm_runctl_chk #(
  parameter int CNT_W  = 14,
  parameter int TAIL_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_halt,
  input logic              trace_clr_wr,
  input logic [4:0]        status,
  input logic              wb_drop,
  input logic [CNT_W-1:0]  eof_cnt,
  input logic              eof_ovf,
  input logic [TAIL_W-1:0] tail_left,
  input logic              tail_done,
  input logic              fifo_rst_pulse
);
  // R1: state bits one-hot
  p_onehot_state_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(status[3:0]) == 1);
  // R3: halt never leads to run
  p_halt_not_run_r3: assert property (@(posedge clk) disable iff (rst)
    ctl_halt |=> !status[1]);
  // R5: a dropped write-back coincides with idle
  p_drop_idle_r5: assert property (@(posedge clk) disable iff (rst)
    wb_drop |-> status[0]);
  // R8: captured count frozen while overload set
  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (eof_ovf && !trace_clr_wr) |=> $stable(eof_cnt));
  // R9: clear wipes trace
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    trace_clr_wr |=> (eof_cnt == '0 && !eof_ovf));
  // R10: done only with counter at zero
  p_tail_zero_r10: assert property (@(posedge clk) disable iff (rst)
    tail_done |-> (tail_left == '0));
  // R12: FIFO reset lasts one cycle
  p_fifo_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    fifo_rst_pulse |=> !fifo_rst_pulse);
endmodule

bind strm_runctl strm_runctl_chk #(.CNT_W(CNT_W), .TAIL_W(TAIL_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_halt(ctl_halt), .trace_clr_wr(trace_clr_wr),
  .status(status), .wb_drop(wb_drop), .eof_cnt(eof_cnt), .eof_ovf(eof_ovf),
  .tail_left(tail_left), .tail_done(tail_done), .fifo_rst_pulse(fifo_rst_pulse)
);

// File: tb/strm_runctl_test.sv
module strm_runctl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_en, ctl_pause, ctl_halt, halt_drop, wb_busy;
  logic        rd_skip, rd_valid, eof_in, eof_ack, bit_step;
  logic        trace_clr_wr, fifo_rst_wr, fifo_empty_in;
  logic [13:0] byte_cnt;
  logic [15:0] tail_len;
  logic [4:0]  status;
  logic        wb_drop, eof_ovf, tail_done, rd_hold, fifo_rst_pulse;
  logic [13:0] eof_cnt;
  logic [15:0] tail_left;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  strm_runctl uut (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_pause(ctl_pause),
    .ctl_halt(ctl_halt), .halt_drop(halt_drop), .wb_busy(wb_busy),
    .rd_skip(rd_skip), .rd_valid(rd_valid), .eof_in(eof_in), .eof_ack(eof_ack),
    .byte_cnt(byte_cnt), .tail_len(tail_len), .bit_step(bit_step),
    .trace_clr_wr(trace_clr_wr), .fifo_rst_wr(fifo_rst_wr),
    .fifo_empty_in(fifo_empty_in), .status(status), .wb_drop(wb_drop),
    .eof_cnt(eof_cnt), .eof_ovf(eof_ovf), .tail_left(tail_left),
    .tail_done(tail_done), .rd_hold(rd_hold), .fifo_rst_pulse(fifo_rst_pulse)
  );

  // {en, pause, halt, drop_mode, wb_busy, exp {pause,wait,run,idle}, exp wb_drop}
  localparam logic [9:0] VEC [16] = '{
    10'b10000_0010_0,  // R2 run
    10'b11000_1000_0,  // R3 pause over run
    10'b11100_0001_0,  // R3 halt over pause, no write-back
    10'b10001_0010_0,  // R2 run with busy
    10'b10101_0100_0,  // R4 wait
    10'b10101_0100_0,  // R4 stay in wait
    10'b10100_0001_0,  // R4 done -> idle
    10'b10000_0010_0,  // R2
    10'b10111_0001_1,  // R5 drop
    10'b00000_0001_0,  // R6
    10'b10000_0010_0,  // R2
    10'b00000_0001_0,  // R6
    10'b11000_1000_0,  // R3 pause from idle
    10'b10000_0010_0,  // R2
    10'b10101_0100_0,  // R4 wait
    10'b10111_0001_1   // R5 drop from wait
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_run();
    ctl_en = 1; ctl_pause = 0; ctl_halt = 0; halt_drop = 0; wb_busy = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; ctl_en = 0; ctl_pause = 0; ctl_halt = 1; halt_drop = 0; wb_busy = 0;
    rd_skip = 0; rd_valid = 0; eof_in = 0; eof_ack = 0; bit_step = 0;
    trace_clr_wr = 0; fifo_rst_wr = 0; fifo_empty_in = 1;
    byte_cnt = '0; tail_len = '0;
    @(negedge clk); step(); step();
    rst = 0;
    // R1 reset state
    check("R1 status", int'(status), 5'b10001);
    check("R1 eof_cnt", int'(eof_cnt), 0);
    check("R1 eof_ovf", int'(eof_ovf), 0);
    check("R1 fifo_rst_pulse", int'(fifo_rst_pulse), 0);
    check("R1 tail_done", int'(tail_done), 0);

    for (int i = 0; i < 16; i++) begin
      {ctl_en, ctl_pause, ctl_halt, halt_drop, wb_busy} = VEC[i][9:5];
      step();
      check($sformatf("R2-table state row %0d", i), int'(status[3:0]), int'(VEC[i][4:1]));
      check($sformatf("R5 wb_drop row %0d", i), int'(wb_drop), int'(VEC[i][0]));
    end

    // R7 capture
    byte_cnt = 14'd100; eof_in = 1; tail_len = 16'd5; step();
    eof_in = 0;
    check("R7 eof_cnt", int'(eof_cnt), 100);
    check("R7 eof_ovf", int'(eof_ovf), 0);
    // R8 overload keeps first
    byte_cnt = 14'd200; eof_in = 1; step();
    eof_in = 0;
    check("R8 eof_ovf", int'(eof_ovf), 1);
    check("R8 eof_cnt held", int'(eof_cnt), 100);
    byte_cnt = 14'd222; eof_in = 1; eof_ack = 1; step();
    eof_in = 0; eof_ack = 0;
    check("R8 eof_cnt held after ack", int'(eof_cnt), 100);
    // R9 clear, with a simultaneous end-of-frame
    trace_clr_wr = 1; eof_in = 1; byte_cnt = 14'd333; step();
    trace_clr_wr = 0; eof_in = 0;
    check("R9 eof_cnt", int'(eof_cnt), 0);
    check("R9 eof_ovf", int'(eof_ovf), 0);
    // R7 capture after clear, then ack in same cycle as new eof
    byte_cnt = 14'd300; eof_in = 1; step();
    byte_cnt = 14'd400; eof_ack = 1; step();
    eof_in = 0; eof_ack = 0;
    check("R7 ack same cycle eof_cnt", int'(eof_cnt), 400);
    check("R7 ack same cycle eof_ovf", int'(eof_ovf), 0);
    trace_clr_wr = 1; step(); trace_clr_wr = 0;

    // R10 tail countdown in run
    set_run(); step();
    tail_len = 16'd3; eof_in = 1; step();
    eof_in = 0;
    check("R10 tail load", int'(tail_left), 3);
    check("R10 no done at load", int'(tail_done), 0);
    bit_step = 1; step();
    check("R10 tail 2", int'(tail_left), 2);
    step();
    check("R10 tail 1", int'(tail_left), 1);
    check("R10 not done at 1", int'(tail_done), 0);
    step();
    bit_step = 0;
    check("R10 tail 0", int'(tail_left), 0);
    check("R10 done pulse", int'(tail_done), 1);
    step();
    check("R10 done one cycle", int'(tail_done), 0);
    tail_len = 16'd0; eof_in = 1; step();
    eof_in = 0;
    check("R10 zero length done", int'(tail_done), 1);
    // R10 no count while paused
    tail_len = 16'd2; eof_in = 1; ctl_pause = 1; step();
    eof_in = 0;
    check("R3 paused", int'(status[3:0]), 4'b1000);
    bit_step = 1; step(); step();
    bit_step = 0;
    check("R10 paused no decrement", int'(tail_left), 2);
    set_run(); step();

    // R11 read hold
    trace_clr_wr = 1; step(); trace_clr_wr = 0;
    rd_skip = 0; eof_in = 1; step();
    eof_in = 0;
    check("R11 hold set", int'(rd_hold), 1);
    step();
    check("R11 hold kept", int'(rd_hold), 1);
    rd_valid = 1; step(); rd_valid = 0;
    check("R11 hold released", int'(rd_hold), 0);
    rd_skip = 1; eof_in = 1; step();
    eof_in = 0;
    check("R11 skip no hold", int'(rd_hold), 0);

    // R12 FIFO reset pulse and empty mirror
    fifo_rst_wr = 1; step();
    check("R12 pulse", int'(fifo_rst_pulse), 1);
    step();
    fifo_rst_wr = 0;
    check("R12 held strobe single pulse", int'(fifo_rst_pulse), 0);
    step();
    check("R12 pulse gone", int'(fifo_rst_pulse), 0);
    fifo_empty_in = 0; step();
    check("R12 empty low", int'(status[4]), 0);
    fifo_empty_in = 1; step();
    check("R12 empty high", int'(status[4]), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule